// File: doc/BRIEF.md
# Quantize-and-Max-Pool Unit

This block turns signed fixed-point accumulator results from a convolution or fully connected array into 2-bit activation codes. It takes the magnitude of each value and runs it through three pipelined threshold stages. The first stage tests the highest threshold and the last stage the lowest. When a stage finds that a pixel exceeds its threshold, it sets a flag. That flag stops the later stages from comparing the same pixel, and the decided code moves down the pipeline unchanged.

A one-bit mode input picks one of two behaviours. In quantize-only mode every valid pixel is handled on its own and gives one code per cycle. In pooling mode, the pixels of a window arrive one per cycle, bracketed by a start flag and an end flag. Each stage flag then stays set until the next window starts, and the unit gives a single code at the end of the window: the quantized maximum of the window. No separate pooling hardware is needed. The window length is whatever the feeder marks with the start and end flags.

Top module: `qmaxpool_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and `out_code` to 0 and clears every stage flag. A pooling pixel that follows reset without a start flag is judged only on its own value.
- R2: The unit quantizes the two's-complement magnitude of `in_data`. A negative input gives the same code as its positive counterpart. The most negative value gives its full positive magnitude (code 3).
- R3: With ONE = 2^FRAC_W, the thresholds are T_HI = floor(5*ONE/6), T_MID = floor(ONE/2) and T_LO = floor(ONE/6). The code is 3 if the magnitude is greater than T_HI, 2 if greater than T_MID, 1 if greater than T_LO, and 0 otherwise. Every compare is strict. Codes 0..3 stand for 0, 1/3, 2/3 and 1. Magnitudes above ONE give code 3 with no clamp.
- R4: When `pool_mode` is 0, each pixel sampled with `in_valid` high gives exactly one `out_valid` pulse. The pulse is registered on the third rising edge after the sampling edge. Back-to-back pixels give back-to-back results, and no result depends on earlier pixels.
- R5: When `pool_mode` is 1, a window runs from the pixel with `in_first` high to the pixel with `in_last` high. Its single result is the highest code among its pixels, whatever the order in which they arrive.
- R6: In pooling mode, `out_valid` rises only for the window-end pixel. It is registered on the third rising edge after that pixel is sampled and lasts one cycle. Pixels that do not end a window give no output.
- R7: A pixel with `in_first` high clears the window state of all stages. A larger pixel in an earlier window never raises the result of a later window, even when the two windows are back to back.
- R8: A cycle with `in_valid` low is ignored, including inside a pooling window. Its data, mode and window flags neither produce an output nor change the window result.
- R9: A pooling window may hold a single pixel (`in_first` and `in_last` both high). Its result is that pixel's own code.
- R10: Once a stage has decided a pixel's code, the later stages pass that code on unchanged and keep their own compares idle. A window whose highest pixel arrives first still yields that pixel's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pool_mode | input | 1 | 1: quantize with max-pooling, 0: quantize only (taken per pixel) |
| in_valid | input | 1 | Pixel present this cycle |
| in_first | input | 1 | Pixel opens a pooling window |
| in_last | input | 1 | Pixel closes a pooling window |
| in_data | input | ACC_W | Signed fixed-point accumulator value, FRAC_W fraction bits |
| out_valid | output | 1 | One-cycle strobe marking a result |
| out_code | output | 2 | Quantized activation code |

## Verification
Window clearing and result release can fall in the same cycle. When two pooling windows run back to back, the end pixel of one window sits in the last stage while the start pixel of the next clears the flags of the earlier stages. The vector table provokes this with a window whose large last pixel is followed at once by a window of smaller values and an idle gap. It then judges both released codes: a leak of flags across the boundary would raise the second code, and a clear applied too early would lower the first.

// File: rtl/qmp_pkg.sv
package qmp_pkg;

  typedef enum logic {
    MODE_QONLY = 1'b0,
    MODE_POOL  = 1'b1
  } qmode_e;

  localparam int CODE_W     = 2;
  localparam int NUM_STAGES = 3;

  typedef logic [CODE_W-1:0] qcode_t;

  // Threshold of a stage: stage 0 tests the highest level (5/6), stage 1
  // the middle level (1/2), stage 2 the lowest level (1/6).
  function automatic int unsigned stage_thresh(input int unsigned frac_w, input int stage);
    int unsigned one;
    one = 32'd1 << frac_w;
    case (stage)
      0:       return (5 * one) / 6;
      1:       return one / 2;
      default: return one / 6;
    endcase
  endfunction

  // Code that a stage issues when its threshold is exceeded.
  function automatic qcode_t stage_level(input int stage);
    return qcode_t'(NUM_STAGES - stage);
  endfunction

endpackage

// File: rtl/qmp_absfront.sv
module qmp_absfront #(
  parameter int ACC_W = 16
) (
  input  logic signed [ACC_W-1:0] i_data,
  output logic        [ACC_W-1:0] o_mag
);

  // The magnitude is unsigned, so the most negative input keeps its full
  // value of 2^(ACC_W-1).
  always_comb begin
    if (i_data[ACC_W-1]) o_mag = $unsigned(-i_data);
    else                 o_mag = $unsigned(i_data);
  end

endmodule

// File: rtl/qmp_stage.sv
module qmp_stage
  import qmp_pkg::*;
#(
  parameter int          MAG_W  = 16,
  parameter int unsigned THRESH = 0,
  parameter qcode_t      LEVEL  = 2'd3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_valid,
  input  logic             i_pool,
  input  logic             i_first,
  input  logic             i_last,
  input  logic [MAG_W-1:0] i_mag,
  input  qcode_t           i_code,
  input  logic             i_blk,
  output logic             o_valid,
  output logic             o_pool,
  output logic             o_first,
  output logic             o_last,
  output logic [MAG_W-1:0] o_mag,
  output qcode_t           o_code,
  output logic             o_blk
);

  localparam logic [MAG_W-1:0] THR = MAG_W'(THRESH);

  logic keep;
  logic cmp_en;
  logic cmp_hit;

  // In pooling mode a flag that is already set holds for the rest of the
  // window. A window start drops it.
  assign keep    = i_pool & ~i_first & o_blk;
  // The comparator is only enabled when no earlier decision exists.
  assign cmp_en  = i_valid & ~i_blk & ~keep;
  assign cmp_hit = cmp_en & (i_mag > THR);

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_pool  <= 1'b0;
      o_first <= 1'b0;
      o_last  <= 1'b0;
      o_mag   <= '0;
      o_code  <= '0;
      o_blk   <= 1'b0;
    end else begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_pool  <= i_pool;
        o_first <= i_first;
        o_last  <= i_last;
        o_mag   <= i_mag;
        o_blk   <= i_blk | keep | cmp_hit;
        if (i_blk)                o_code <= i_code;
        else if (keep | cmp_hit)  o_code <= LEVEL;
        else                      o_code <= '0;
      end
    end
  end

  AST_BLOCK_CARRY: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_blk) |=> (o_blk && o_code == $past(i_code))); // R10

  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_pool && !i_first && o_blk) |=> o_blk); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> ($stable(o_code) && $stable(o_blk))); // R8

endmodule

// File: rtl/qmaxpool_unit.sv
module qmaxpool_unit
  import qmp_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pool_mode,
  input  logic                    in_valid,
  input  logic                    in_first,
  input  logic                    in_last,
  input  logic signed [ACC_W-1:0] in_data,
  output logic                    out_valid,
  output logic [CODE_W-1:0]       out_code
);

  localparam int LAST = NUM_STAGES;

  logic [NUM_STAGES:0] s_valid;
  logic [NUM_STAGES:0] s_pool;
  logic [NUM_STAGES:0] s_first;
  logic [NUM_STAGES:0] s_last;
  logic [NUM_STAGES:0] s_blk;
  logic [ACC_W-1:0]    s_mag  [NUM_STAGES+1];
  qcode_t              s_code [NUM_STAGES+1];
  logic                release_now;

  qmp_absfront #(.ACC_W(ACC_W)) u_abs (
    .i_data (in_data),
    .o_mag  (s_mag[0])
  );

  assign s_valid[0] = in_valid;
  assign s_pool[0]  = (pool_mode == MODE_POOL);
  assign s_first[0] = in_first;
  assign s_last[0]  = in_last;
  assign s_blk[0]   = 1'b0;
  assign s_code[0]  = '0;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    qmp_stage #(
      .MAG_W  (ACC_W),
      .THRESH (stage_thresh(FRAC_W, g)),
      .LEVEL  (stage_level(g))
    ) u_stage (
      .clk     (clk),
      .rst     (rst),
      .i_valid (s_valid[g]),
      .i_pool  (s_pool[g]),
      .i_first (s_first[g]),
      .i_last  (s_last[g]),
      .i_mag   (s_mag[g]),
      .i_code  (s_code[g]),
      .i_blk   (s_blk[g]),
      .o_valid (s_valid[g+1]),
      .o_pool  (s_pool[g+1]),
      .o_first (s_first[g+1]),
      .o_last  (s_last[g+1]),
      .o_mag   (s_mag[g+1]),
      .o_code  (s_code[g+1]),
      .o_blk   (s_blk[g+1])
    );
  end

  // A quantize-only pixel is released at once. A pooling result waits for
  // the window-end pixel.
  assign release_now = s_valid[LAST] & (~s_pool[LAST] | s_last[LAST]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= release_now;
      if (release_now) out_code <= s_code[LAST];
    end
  end

  function automatic qcode_t quantize(input logic [ACC_W-1:0] m);
    if (m > ACC_W'(stage_thresh(FRAC_W, 0)))      return 2'd3;
    else if (m > ACC_W'(stage_thresh(FRAC_W, 1))) return 2'd2;
    else if (m > ACC_W'(stage_thresh(FRAC_W, 2))) return 2'd1;
    else                                          return 2'd0;
  endfunction

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 4)); // R4

  AST_QONLY_STREAM: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid, 4) && !$past(pool_mode, 4) && !$past(rst, 1) && !$past(rst, 2)
     && !$past(rst, 3) && !$past(rst, 4)) |-> out_valid); // R4

  AST_POOL_END_ONLY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(pool_mode, 4)) |-> $past(in_last, 4)); // R6

  AST_UNFLAGGED_BELOW: assert property (@(posedge clk) disable iff (rst)
    (s_valid[LAST] && !s_blk[LAST]) |-> (s_mag[LAST] <= ACC_W'(stage_thresh(FRAC_W, 2)))); // R3

  AST_SINGLE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (s_valid[LAST] && s_pool[LAST] && s_first[LAST] && s_last[LAST])
      |-> (s_code[LAST] == quantize(s_mag[LAST]))); // R9

endmodule

// File: tb/qmaxpool_unit_bench.sv
module qmaxpool_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ACC_W      = 16;
  localparam int FRAC_W     = 8;
  localparam int NV         = 20;

  // {valid, pool, first, last, data[15:0], exp_valid, exp_code[1:0]}
  // Thresholds for FRAC_W=8: T_HI=213, T_MID=128, T_LO=42.
  localparam logic [22:0] VEC [NV] = '{
    {4'b1000, 16'd0,     1'b1, 2'd0},  // 0  R3 zero
    {4'b1000, 16'd43,    1'b1, 2'd1},  // 1  R3 just above T_LO
    {4'b1000, 16'hFF7F,  1'b1, 2'd2},  // 2  R2 -129
    {4'b1000, 16'd214,   1'b1, 2'd3},  // 3  R3 just above T_HI
    {4'b1000, 16'd213,   1'b1, 2'd2},  // 4  R3 equal T_HI
    {4'b1000, 16'd1000,  1'b1, 2'd3},  // 5  R3 above one
    {4'b1000, 16'h8000,  1'b1, 2'd3},  // 6  R2 most negative
    {4'b1000, 16'd42,    1'b1, 2'd0},  // 7  R3 equal T_LO
    {4'b1110, 16'd50,    1'b0, 2'd0},  // 8  R6 window A start
    {4'b1100, 16'd130,   1'b0, 2'd0},  // 9  R6
    {4'b1101, 16'd300,   1'b1, 2'd3},  // 10 R5 window A end
    {4'b1110, 16'd129,   1'b0, 2'd0},  // 11 R7 window B start
    {4'b0110, 16'd5000,  1'b0, 2'd0},  // 12 R8 idle gap
    {4'b1101, 16'd20,    1'b1, 2'd2},  // 13 R7 window B end
    {4'b1111, 16'hFF9C,  1'b1, 2'd1},  // 14 R9 single -100
    {4'b1000, 16'd128,   1'b1, 2'd1},  // 15 R4 equal T_MID
    {4'b1110, 16'd214,   1'b0, 2'd0},  // 16 R10 max first
    {4'b1100, 16'd0,     1'b0, 2'd0},  // 17 R10
    {4'b1101, 16'hFFCE,  1'b1, 2'd3},  // 18 R10 end
    {4'b1000, 16'd0,     1'b1, 2'd0}   // 19 R4
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              pool_mode;
  logic              in_valid;
  logic              in_first;
  logic              in_last;
  logic signed [15:0] in_data;
  logic              out_valid;
  logic [1:0]        out_code;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  qmaxpool_unit #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_qmaxpool_unit (
    .clk       (clk),
    .rst       (rst),
    .pool_mode (pool_mode),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_last   (in_last),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_code  (out_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_of(input int idx);
    case (idx)
      2, 6:           return "R2";
      0, 1, 3, 4, 5, 7: return "R3";
      8, 9:           return "R6";
      10:             return "R5";
      11, 13:         return "R7";
      12:             return "R8";
      14:             return "R9";
      16, 17, 18:     return "R10";
      default:        return "R4";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic p, input logic f, input logic l,
                       input logic [15:0] d);
    in_valid  = v;
    pool_mode = p;
    in_first  = f;
    in_last   = l;
    in_data   = d;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'd0);
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "out_code in reset", int'(out_code), 0);
    rst = 1'b0;

    // Table walk: result of entry j-4 is visible at negedge j.
    for (int j = 0; j < NV + 4; j++) begin
      @(negedge clk);
      if (j >= 4) begin
        logic [22:0] e;
        e = VEC[j-4];
        check(req_of(j-4), $sformatf("entry %0d out_valid", j-4), int'(out_valid), int'(e[2]));
        if (e[2]) check(req_of(j-4), $sformatf("entry %0d out_code", j-4), int'(out_code), int'(e[1:0]));
      end
      if (j < NV) drive(VEC[j][22], VEC[j][21], VEC[j][20], VEC[j][19], VEC[j][18:3]);
      else        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'd0);
    end

    // Reset in the middle of a window with high pixels.
    @(negedge clk); drive(1'b1, 1'b1, 1'b1, 1'b0, 16'd1000);
    @(negedge clk); drive(1'b1, 1'b1, 1'b0, 1'b0, 16'd600);
    @(negedge clk); drive(1'b0, 1'b0, 1'b0, 1'b0, 16'd0); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "out_code after reset", int'(out_code), 0);
    rst = 1'b0;
    // Continuation pixel without a start flag: only its own value counts.
    drive(1'b1, 1'b1, 1'b0, 1'b1, 16'd50);
    @(negedge clk); drive(1'b0, 1'b0, 1'b0, 1'b0, 16'd0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check("R1", "post-reset window valid", int'(out_valid), 1);
    check("R1", "post-reset window code", int'(out_code), 1);
    @(negedge clk);
    check("R6", "strobe lasts one cycle", int'(out_valid), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule